// File: doc/BRIEF.md
# Privileged Soft Interrupt Pending Register

This block holds a 17-bit word of software-raised interrupt requests. Supervisor code reaches it through a small register-access port that maps three write addresses onto the same storage. One address overwrites the word. One ORs the write data into it. One clears the bits that are set in the write data. A read at any of the three addresses returns the stored word.

Every access checks the privilege input. An access from user mode changes nothing and reports a fault. An address outside the three mapped slots reports a separate fault.

After each accepted write, the block compares the highest pending interrupt level before and after the write. When the level rises, it raises a one-cycle strobe. The strobe tells the surrounding interrupt logic to re-evaluate pending requests.

Top module: `sint_pend_reg`

## Requirements
- R1: Any read or write while `acc_priv` is 0 leaves the stored word unchanged. On the next cycle `acc_fault` is 1 (privileged-opcode fault) and `acc_rdata` is 0.
- R2: A privileged write to address 1 (clear slot) stores `old & ~acc_wdata`.
- R3: A privileged write to address 2 (set slot) stores `old | acc_wdata`.
- R4: A privileged write to address 0 (direct slot) stores `acc_wdata`.
- R5: A privileged read at address 0, 1 or 2 returns the stored word on `acc_rdata` one cycle later, with `acc_fault` 0. `acc_rdata` is 0 in every cycle that does not follow an accepted read.
- R6: The level of a word is the index of its highest set bit among bits 15 down to 1, or 0 when none of those bits is set. Bits 0 and 16 never count.
  - `recheck_o` is high for exactly the one cycle after an accepted write whose new level exceeds the old level.
  - It stays low otherwise, including for writes that leave the level equal or lower it.
- R7: A privileged access to address 3 leaves the word unchanged. On the next cycle `acc_fault` is 2 (illegal-access fault) and `acc_rdata` is 0.
- R8: Synchronous active-high reset clears the word, `acc_rdata`, `acc_fault` and `recheck_o` to 0.
- R9: When a privileged read and write are presented in the same cycle, the read returns the word as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_wr | input | 1 | Write request |
| acc_rd | input | 1 | Read request |
| acc_addr | input | 2 | Slot: 0 direct, 1 clear, 2 set, 3 unmapped |
| acc_wdata | input | 17 | Write data |
| acc_priv | input | 1 | 1 when the requester is privileged |
| acc_rdata | output | 17 | Registered read data |
| acc_fault | output | 2 | Registered fault: 0 none, 1 privilege, 2 illegal |
| recheck_o | output | 1 | One-cycle strobe when the pending level rises |

## Verification
Directed steps walk the word through each of the three write slots, with a read after each write. These reads tell the overwrite, OR and AND-NOT updates apart. Targeted writes then exercise the strobe:
- setting only bit 0 or bit 16,
- rewriting at the same level,
- dropping the level,
- raising it to bit 15.

These separate a correct level comparison from one that counts the wrong bits or fires on any change.

A long seeded random run then mixes the following, against a bench-side model of the word:
- full-width, single-bit and zero write data,
- user-mode and unmapped accesses,
- same-cycle read-and-write.

The random run catches faults that leak state and reads that see the new value instead of the old one.

// File: rtl/sint_pkg.sv
package sint_pkg;

    parameter int unsigned SI_WIDTH = 17;
    parameter int unsigned LVL_LO   = 1;
    parameter int unsigned LVL_HI   = 15;
    localparam int unsigned LVL_W   = $clog2(LVL_HI + 1);
    localparam int unsigned ADDR_W  = 2;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_PRIV    = 2'd1,
        FLT_ILLEGAL = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        SLOT_DIRECT = 2'd0,
        SLOT_CLEAR  = 2'd1,
        SLOT_SET    = 2'd2
    } slot_e;

    typedef struct packed {
        logic   wr_ok;
        logic   rd_ok;
        slot_e  slot;
        fault_e fault;
    } acc_op_t;

    // Highest set index within [LVL_HI:LVL_LO], zero when none.
    function automatic logic [LVL_W-1:0] si_level(input logic [SI_WIDTH-1:0] v);
        logic [LVL_W-1:0] r;
        r = '0;
        for (int i = LVL_LO; i <= LVL_HI; i++) begin
            if (v[i]) r = LVL_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/sint_decode.sv
module sint_decode
    import sint_pkg::*;
#(
    parameter int unsigned AW = ADDR_W
) (
    input  logic          wr,
    input  logic          rd,
    input  logic          priv,
    input  logic [AW-1:0] addr,
    output acc_op_t       op
);
    localparam int unsigned NUM_SLOTS = 3;

    always_comb begin
        op       = '0;
        op.slot  = SLOT_DIRECT;
        op.fault = FLT_NONE;
        if (wr || rd) begin
            if (!priv) begin
                op.fault = FLT_PRIV;
            end else if (int'(addr) >= NUM_SLOTS) begin
                op.fault = FLT_ILLEGAL;
            end else begin
                op.wr_ok = wr;
                op.rd_ok = rd;
                op.slot  = slot_e'(addr[1:0]);
            end
        end
    end

endmodule

// File: rtl/sint_update.sv
module sint_update
    import sint_pkg::*;
#(
    parameter int unsigned W = SI_WIDTH
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] wdata,
    input  acc_op_t      op,
    output logic [W-1:0] nxt
);
    always_comb begin
        nxt = cur;
        if (op.wr_ok) begin
            unique case (op.slot)
                SLOT_DIRECT: nxt = wdata;
                SLOT_CLEAR:  nxt = cur & ~wdata;
                SLOT_SET:    nxt = cur | wdata;
                default:     nxt = cur;
            endcase
        end
    end

endmodule

// File: rtl/sint_level.sv
module sint_level #(
    parameter int unsigned LO = 1,
    parameter int unsigned HI = 15,
    parameter int unsigned LW = $clog2(HI + 1)
) (
    input  logic [HI:LO]  vec,
    output logic [LW-1:0] lvl
);
    logic [HI:LO]         hit;
    logic [HI:LO][LW-1:0] term;

    for (genvar i = LO; i <= HI; i++) begin : g_bit
        if (i == HI) begin : g_top
            assign hit[i] = vec[i];
        end else begin : g_low
            assign hit[i] = vec[i] & ~(|vec[HI:i+1]);
        end
        assign term[i] = hit[i] ? LW'(i) : '0;
    end

    always_comb begin
        lvl = '0;
        for (int j = LO; j <= HI; j++) begin
            lvl = lvl | term[j];
        end
    end

endmodule

// File: rtl/sint_pend_reg.sv
module sint_pend_reg
    import sint_pkg::*;
#(
    parameter int unsigned W  = SI_WIDTH,
    parameter int unsigned LO = LVL_LO,
    parameter int unsigned HI = LVL_HI,
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_wr,
    input  logic          acc_rd,
    input  logic [AW-1:0] acc_addr,
    input  logic [W-1:0]  acc_wdata,
    input  logic          acc_priv,
    output logic [W-1:0]  acc_rdata,
    output logic [1:0]    acc_fault,
    output logic          recheck_o
);
    localparam int unsigned LW = $clog2(HI + 1);

    acc_op_t       op;
    logic [W-1:0]  pend_q;
    logic [W-1:0]  pend_d;
    logic [LW-1:0] lvl_old;
    logic [LW-1:0] lvl_new;

    sint_decode #(.AW(AW)) u_dec (
        .wr   (acc_wr),
        .rd   (acc_rd),
        .priv (acc_priv),
        .addr (acc_addr),
        .op   (op)
    );

    sint_update #(.W(W)) u_upd (
        .cur   (pend_q),
        .wdata (acc_wdata),
        .op    (op),
        .nxt   (pend_d)
    );

    sint_level #(.LO(LO), .HI(HI), .LW(LW)) u_lvl_old (
        .vec (pend_q[HI:LO]),
        .lvl (lvl_old)
    );

    sint_level #(.LO(LO), .HI(HI), .LW(LW)) u_lvl_new (
        .vec (pend_d[HI:LO]),
        .lvl (lvl_new)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            acc_rdata <= '0;
            acc_fault <= FLT_NONE;
            recheck_o <= 1'b0;
        end else begin
            pend_q    <= pend_d;
            acc_rdata <= op.rd_ok ? pend_q : '0;
            acc_fault <= op.fault;
            recheck_o <= op.wr_ok && (lvl_new > lvl_old);
        end
    end

endmodule

// File: rtl/sint_pend_chk.sv
module sint_pend_chk
    import sint_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                wr,
    input logic                rd,
    input logic [1:0]          addr,
    input logic [SI_WIDTH-1:0] wdata,
    input logic                priv,
    input logic [SI_WIDTH-1:0] rdata,
    input logic [1:0]          fault,
    input logic                recheck,
    input logic [SI_WIDTH-1:0] pend
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (pend == '0 && !recheck && fault == 2'd0 && rdata == '0)); // R8

    AST_USER_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        ((wr || rd) && !priv) |=> (fault == 2'd1 && pend == $past(pend) && rdata == '0)); // R1

    AST_UNMAPPED: assert property (@(posedge clk) disable iff (rst)
        ((wr || rd) && priv && addr == 2'd3) |=> (fault == 2'd2 && $stable(pend))); // R7

    AST_CLEAR_SLOT: assert property (@(posedge clk) disable iff (rst)
        (wr && priv && addr == 2'd1) |=> (pend == ($past(pend) & ~$past(wdata)))); // R2

    AST_SET_SLOT: assert property (@(posedge clk) disable iff (rst)
        (wr && priv && addr == 2'd2) |=> (pend == ($past(pend) | $past(wdata)))); // R3

    AST_DIRECT_SLOT: assert property (@(posedge clk) disable iff (rst)
        (wr && priv && addr == 2'd0) |=> (pend == $past(wdata))); // R4

    AST_READ_OLD: assert property (@(posedge clk) disable iff (rst)
        (rd && priv && addr != 2'd3) |=> (rdata == $past(pend) && fault == 2'd0)); // R9

    AST_RECHECK_RISE: assert property (@(posedge clk) disable iff (rst)
        recheck |-> (si_level(pend) > si_level($past(pend)))); // R6

endmodule

bind sint_pend_reg sint_pend_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr      (acc_wr),
    .rd      (acc_rd),
    .addr    (acc_addr),
    .wdata   (acc_wdata),
    .priv    (acc_priv),
    .rdata   (acc_rdata),
    .fault   (acc_fault),
    .recheck (recheck_o),
    .pend    (pend_q)
);

// File: tb/test_sint_pend_reg.sv
`timescale 1ns/1ps
module test_sint_pend_reg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_wr = 1'b0;
    logic        acc_rd = 1'b0;
    logic [1:0]  acc_addr = '0;
    logic [16:0] acc_wdata = '0;
    logic        acc_priv = 1'b0;
    logic [16:0] acc_rdata;
    logic [1:0]  acc_fault;
    logic        recheck_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [16:0] model = '0;

    always #4 clk = ~clk;

    sint_pend_reg i_sint_pend_reg (
        .clk       (clk),
        .rst       (rst),
        .acc_wr    (acc_wr),
        .acc_rd    (acc_rd),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_priv  (acc_priv),
        .acc_rdata (acc_rdata),
        .acc_fault (acc_fault),
        .recheck_o (recheck_o)
    );

    function automatic int lvl_of(input logic [16:0] v);
        for (int i = 15; i >= 1; i--) if (v[i]) return i;
        return 0;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input bit wr, input bit rd, input logic [1:0] addr,
                         input logic [16:0] wd, input bit priv, input string rtag);
        logic [1:0]  e_fault;
        logic [16:0] e_rd;
        logic [16:0] e_new;
        bit          e_rck;
        string       ftag;
        string       dtag;
        e_fault = 2'd0;
        if (wr || rd) begin
            if (!priv) e_fault = 2'd1;
            else if (addr == 2'd3) e_fault = 2'd2;
        end
        e_rd  = (rd && e_fault == 2'd0) ? model : 17'h0;
        e_new = model;
        if (wr && e_fault == 2'd0) begin
            case (addr)
                2'd0: e_new = wd;
                2'd1: e_new = model & ~wd;
                default: e_new = model | wd;
            endcase
        end
        e_rck = wr && e_fault == 2'd0 && (lvl_of(e_new) > lvl_of(model));
        ftag = !priv ? "R1" : (addr == 2'd3 ? "R7" : "R5");
        if (rtag != "") dtag = rtag;
        else if (wr && rd && e_fault == 2'd0) dtag = "R9";
        else dtag = ftag;
        acc_wr = wr; acc_rd = rd; acc_addr = addr; acc_wdata = wd; acc_priv = priv;
        @(negedge clk);
        acc_wr = 1'b0; acc_rd = 1'b0;
        check(ftag, "fault", 32'(acc_fault), 32'(e_fault));
        check(dtag, "rdata", 32'(acc_rdata), 32'(e_rd));
        check("R6", "recheck", 32'(recheck_o), 32'(e_rck));
        model = e_new;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8", "rdata in reset", 32'(acc_rdata), 32'h0);
        check("R8", "fault in reset", 32'(acc_fault), 32'h0);
        check("R8", "recheck in reset", 32'(recheck_o), 32'h0);
        rst = 1'b0;
        do_op(0, 1, 2'd0, 17'h0, 1, "R8");            // word is zero after reset
        do_op(1, 0, 2'd0, 17'h00010, 1, "");          // R4 direct, level 0->4
        do_op(0, 1, 2'd0, 17'h0, 1, "R4");
        do_op(1, 0, 2'd2, 17'h00101, 1, "");          // R3 set, level 4->8
        do_op(0, 1, 2'd2, 17'h0, 1, "R3");
        do_op(1, 0, 2'd1, 17'h00011, 1, "");          // R2 clear
        do_op(0, 1, 2'd1, 17'h0, 1, "R2");
        do_op(1, 0, 2'd0, 17'h1FFFF, 0, "");          // R1 user write blocked
        do_op(0, 1, 2'd0, 17'h0, 0, "");              // R1 user read
        do_op(0, 1, 2'd0, 17'h0, 1, "R1");
        do_op(1, 1, 2'd3, 17'h1FFFF, 1, "");          // R7 unmapped
        do_op(0, 1, 2'd0, 17'h0, 1, "R7");
        do_op(1, 0, 2'd2, 17'h10001, 1, "");          // R6 bits 16 and 0 ignored
        do_op(1, 0, 2'd0, 17'h00180, 1, "");          // R6 equal level
        do_op(1, 0, 2'd0, 17'h00002, 1, "");          // R6 falling level
        do_op(1, 0, 2'd2, 17'h08000, 1, "");          // R6 rise to 15
        do_op(1, 1, 2'd0, 17'h00040, 1, "R9");        // read sees old word
        do_op(0, 1, 2'd0, 17'h0, 1, "R9");
        void'($urandom(32'd20240611));
        for (int k = 0; k < 3000; k++) begin
            logic [16:0] wd;
            case ($urandom % 3)
                0: wd = 17'($urandom);
                1: wd = 17'h1 << ($urandom % 17);
                default: wd = 17'h0;
            endcase
            do_op(1'($urandom), 1'($urandom), 2'($urandom), wd, ($urandom % 5) != 0, "");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog all-requirements actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule